// File: doc/BRIEF.md
# SPI Command Register Bridge

This block is an SPI target (single data line, mode 0, chip select low for the whole command) that lets an external host reach an internal byte-addressed bus. The host moves data in two steps. First it sends a configuration frame that sets a start address and a transfer length, and that also fixes the direction. Then it sends a data frame that carries the bytes. The block turns each data byte into a single-byte read or write on a simple request/acknowledge bus master port, and it adds one to the address after every byte.

An 8-bit status byte records the block's progress and any faults. The host reads it with a two-byte status frame and clears flags with a write-one-to-clear status frame. The SPI pins are sampled by the system clock through synchronizers, so the serial clock must run well below the system clock. The tests use a serial half-period of ten system cycles.

Top module: `spi_cmd_bridge`

## Requirements
- R1: After reset the status byte is 0x01. Status bit positions are: 0 target on, 1 config accepted, 2 data ready, 3 read error, 4 write error, 5 transfer finished, 6 bus timeout, 7 command error. A frame of opcode 0x06 followed by one dummy byte returns the status byte on MISO, MSB first, during the second byte.
- R2: Opcode 0x0C (config for write) or 0x0A (config for read) is followed by a 4-byte address and then a 4-byte value equal to length minus one, each least significant byte first. After the ninth byte, status bits 1 and 2 are set. When a config opcode is received, bits 1, 2 and 5 are cleared and any earlier config is dropped.
- R3: After a write config, opcode 0x0E followed by data bytes writes byte k to address start+k on the bus. Bit 5 sets when the configured length is reached. Bytes beyond that length cause no bus access.
- R4: After a read config, opcode 0x81 returns the bus byte at start+k in frame byte k+1, starting with the byte that follows the opcode.
- R5: A length-minus-one value above 65534 is rejected: bit 7 sets and bits 1 and 2 stay clear. The value 65534 is accepted.
- R6: A data opcode without a valid config of the matching direction sets bit 3 (for 0x81) or bit 4 (for 0x0E) and makes no bus access. A config is used up when its transfer finishes.
- R7: Any opcode outside {0x02, 0x04, 0x06, 0x08, 0x0A, 0x0C, 0x0E, 0x10, 0x81} sets bit 7.
- R8: Opcode 0x08 with one argument byte clears each status bit 7..1 whose argument bit is 1. Bit 0 is never changed by it.
- R9: Opcode 0x10 with argument 0x04 is accepted silently. Any other argument sets bit 7.
- R10: Opcode 0x02 clears status bit 0 and opcode 0x04 sets it.
- R11: If a bus request is not acknowledged within TIMEOUT cycles, it is withdrawn, bit 6 sets, and the data phase and config are dropped.
- R12: Raising chip select part-way through a frame discards the partial frame. The next frame is decoded from its first byte as an opcode.
- R13: While a bus request waits for its acknowledge, the request, address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiSclk | input | 1 | Serial clock from host, idle low |
| spiCsn | input | 1 | Active-low chip select framing a command |
| spiMosi | input | 1 | Host-to-target serial data |
| spiMiso | output | 1 | Target-to-host serial data, low when not selected |
| busReq | output | 1 | Bus request, held until acknowledge or timeout |
| busWe | output | 1 | Bus direction, 1 for write |
| busAddr | output | AW | Bus byte address |
| busWdata | output | 8 | Bus write byte |
| busRdata | input | 8 | Bus read byte, valid with busAck |
| busAck | input | 1 | Bus acknowledge |

## Verification
A received byte takes effect about three system cycles after its eighth serial rising edge: two synchronizer stages plus one registered completion strobe. A bus request follows one cycle after that. Bytes returned on MISO are loaded at the next serial falling edge, so the bench samples MISO just before each rising edge, which is ten cycles after it set MOSI. Status and bus-memory results are checked only after chip select has risen and twenty idle cycles have passed, by which time every bus operation has acknowledged or timed out.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
  localparam logic [7:0] OP_PWR_OFF  = 8'h02;
  localparam logic [7:0] OP_PWR_ON   = 8'h04;
  localparam logic [7:0] OP_RD_STAT  = 8'h06;
  localparam logic [7:0] OP_WR_STAT  = 8'h08;
  localparam logic [7:0] OP_CFG_RD   = 8'h0A;
  localparam logic [7:0] OP_CFG_WR   = 8'h0C;
  localparam logic [7:0] OP_WR_DATA  = 8'h0E;
  localparam logic [7:0] OP_CFG_TYPE = 8'h10;
  localparam logic [7:0] OP_RD_DATA  = 8'h81;
  localparam logic [7:0] MODE_SINGLE_4B = 8'h04;

  localparam int ST_ON   = 0;
  localparam int ST_CFG  = 1;
  localparam int ST_RDY  = 2;
  localparam int ST_RERR = 3;
  localparam int ST_WERR = 4;
  localparam int ST_FIN  = 5;
  localparam int ST_TMO  = 6;
  localparam int ST_CERR = 7;

  // control -> datapath
  typedef struct packed {
    logic       txLoad;
    logic [7:0] txData;
  } txCmd_t;

  // datapath -> control
  typedef struct packed {
    logic       byteDone;
    logic       frameIdle;
    logic [7:0] rxByte;
  } rxEvt_t;
endpackage

// File: rtl/spi_bridge_shift.sv
module spi_bridge_shift
  import spi_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclk,
  input  logic   csn,
  input  logic   mosi,
  input  txCmd_t txCmd,
  output rxEvt_t rxEvt,
  output logic   miso
);
  localparam int BCW = 3;

  logic [SYNC_STAGES:0]   sclkP;
  logic [SYNC_STAGES-1:0] csnP;
  logic [SYNC_STAGES-1:0] mosiP;
  logic [BCW-1:0] bitCnt;
  logic [7:0] rxSh, txSh, txHold;
  logic sclkRise, sclkFall, idle;

  assign sclkRise = sclkP[SYNC_STAGES-1] & ~sclkP[SYNC_STAGES];
  assign sclkFall = ~sclkP[SYNC_STAGES-1] & sclkP[SYNC_STAGES];
  assign idle     = csnP[SYNC_STAGES-1];
  assign miso     = idle ? 1'b0 : txSh[7];
  assign rxEvt.frameIdle = idle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkP <= '0;
      csnP  <= '1;
      mosiP <= '0;
    end else begin
      sclkP <= {sclkP[SYNC_STAGES-1:0], sclk};
      csnP  <= {csnP[SYNC_STAGES-2:0], csn};
      mosiP <= {mosiP[SYNC_STAGES-2:0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxSh   <= '0;
      txSh   <= '0;
      txHold <= '0;
      rxEvt.byteDone <= 1'b0;
      rxEvt.rxByte   <= '0;
    end else begin
      rxEvt.byteDone <= 1'b0;
      if (txCmd.txLoad) txHold <= txCmd.txData;
      if (idle) begin
        bitCnt <= '0;
        rxSh   <= '0;
        txSh   <= '0;
      end else if (sclkRise) begin
        rxSh   <= {rxSh[6:0], mosiP[SYNC_STAGES-1]};
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == '1) begin
          rxEvt.byteDone <= 1'b1;
          rxEvt.rxByte   <= {rxSh[6:0], mosiP[SYNC_STAGES-1]};
        end
      end else if (sclkFall) begin
        if (bitCnt == '0) txSh <= txHold;
        else              txSh <= {txSh[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_bridge_ctrl.sv
module spi_bridge_ctrl
  import spi_bridge_pkg::*;
#(
  parameter int AW      = 32,
  parameter int TIMEOUT = 16,
  parameter int MAXLEN  = 65535
) (
  input  logic          clk,
  input  logic          rstN,
  input  rxEvt_t        rxEvt,
  output txCmd_t        txCmd,
  output logic [7:0]    statusQ,
  output logic          busReq,
  output logic          busWe,
  output logic [AW-1:0] busAddr,
  output logic [7:0]    busWdata,
  input  logic [7:0]    busRdata,
  input  logic          busAck
);
  localparam int LW = $clog2(MAXLEN + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [31:0] LEN_LIMIT = 32'(MAXLEN - 1);

  logic [3:0]    byteIdx;
  logic [7:0]    opcode;
  logic [31:0]   addrSh, lenSh;
  logic          cfgValid, cfgWr, dataOn;
  logic [LW-1:0] cfgLen, rem;
  logic [AW-1:0] cfgAddr, curAddr;
  logic [TW-1:0] tmr;
  logic [7:0]    rx;
  logic [31:0]   lenFull;
  logic          rdDone, statOp;

  assign rx      = rxEvt.rxByte;
  assign lenFull = {rx, lenSh[31:8]};
  assign rdDone  = busReq & busAck & ~busWe;
  assign statOp  = rxEvt.byteDone & ~rxEvt.frameIdle & (byteIdx == 4'd0) & (rx == OP_RD_STAT);

  always_comb begin
    txCmd.txLoad = rdDone | statOp;
    txCmd.txData = rdDone ? busRdata : statusQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= 8'h01;
      byteIdx  <= '0;
      opcode   <= '0;
      addrSh   <= '0;
      lenSh    <= '0;
      cfgValid <= 1'b0;
      cfgWr    <= 1'b0;
      dataOn   <= 1'b0;
      cfgLen   <= '0;
      rem      <= '0;
      cfgAddr  <= '0;
      curAddr  <= '0;
      tmr      <= '0;
      busReq   <= 1'b0;
      busWe    <= 1'b0;
      busAddr  <= '0;
      busWdata <= '0;
    end else begin
      if (busReq) begin
        if (busAck) busReq <= 1'b0;
        else if (tmr == TW'(TIMEOUT - 1)) begin
          busReq           <= 1'b0;
          statusQ[ST_TMO]  <= 1'b1;
          dataOn           <= 1'b0;
          cfgValid         <= 1'b0;
        end else tmr <= tmr + 1'b1;
      end

      if (rxEvt.frameIdle) begin
        byteIdx <= '0;
        dataOn  <= 1'b0;
      end else if (rxEvt.byteDone) begin
        if (byteIdx != '1) byteIdx <= byteIdx + 1'b1;
        if (byteIdx == 4'd0) begin
          opcode <= rx;
          case (rx)
            OP_CFG_RD, OP_CFG_WR: begin
              cfgValid        <= 1'b0;
              cfgWr           <= (rx == OP_CFG_WR);
              statusQ[ST_CFG] <= 1'b0;
              statusQ[ST_RDY] <= 1'b0;
              statusQ[ST_FIN] <= 1'b0;
            end
            OP_PWR_ON:  statusQ[ST_ON] <= 1'b1;
            OP_PWR_OFF: statusQ[ST_ON] <= 1'b0;
            OP_RD_STAT, OP_WR_STAT, OP_CFG_TYPE: ;
            OP_RD_DATA: begin
              if (cfgValid && !cfgWr) begin
                dataOn   <= 1'b1;
                rem      <= cfgLen;
                curAddr  <= cfgAddr;
                busReq   <= 1'b1;
                busWe    <= 1'b0;
                busAddr  <= cfgAddr;
                tmr      <= '0;
              end else statusQ[ST_RERR] <= 1'b1;
            end
            OP_WR_DATA: begin
              if (cfgValid && cfgWr) begin
                dataOn  <= 1'b1;
                rem     <= cfgLen;
                curAddr <= cfgAddr;
              end else statusQ[ST_WERR] <= 1'b1;
            end
            default: statusQ[ST_CERR] <= 1'b1;
          endcase
        end else begin
          case (opcode)
            OP_CFG_RD, OP_CFG_WR: begin
              if (byteIdx <= 4'd4) addrSh <= {rx, addrSh[31:8]};
              else if (byteIdx <= 4'd8) begin
                lenSh <= lenFull;
                if (byteIdx == 4'd8) begin
                  if (lenFull > LEN_LIMIT) statusQ[ST_CERR] <= 1'b1;
                  else begin
                    cfgValid        <= 1'b1;
                    cfgAddr         <= addrSh[AW-1:0];
                    cfgLen          <= lenFull[LW-1:0];
                    statusQ[ST_CFG] <= 1'b1;
                    statusQ[ST_RDY] <= 1'b1;
                  end
                end
              end
            end
            OP_WR_STAT:
              if (byteIdx == 4'd1) statusQ[7:1] <= statusQ[7:1] & ~rx[7:1];
            OP_CFG_TYPE:
              if (byteIdx == 4'd1 && rx != MODE_SINGLE_4B) statusQ[ST_CERR] <= 1'b1;
            OP_WR_DATA: begin
              if (dataOn) begin
                busReq   <= 1'b1;
                busWe    <= 1'b1;
                busAddr  <= curAddr;
                busWdata <= rx;
                tmr      <= '0;
                curAddr  <= curAddr + 1'b1;
                if (rem == '0) begin
                  dataOn          <= 1'b0;
                  cfgValid        <= 1'b0;
                  statusQ[ST_FIN] <= 1'b1;
                end else rem <= rem - 1'b1;
              end
            end
            OP_RD_DATA: begin
              if (dataOn) begin
                if (rem == '0) begin
                  dataOn          <= 1'b0;
                  cfgValid        <= 1'b0;
                  statusQ[ST_FIN] <= 1'b1;
                end else begin
                  rem     <= rem - 1'b1;
                  curAddr <= curAddr + 1'b1;
                  busReq  <= 1'b1;
                  busWe   <= 1'b0;
                  busAddr <= curAddr + 1'b1;
                  tmr     <= '0;
                end
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_bridge.sv
module spi_cmd_bridge
  import spi_bridge_pkg::*;
#(
  parameter int AW      = 32,
  parameter int TIMEOUT = 16,
  parameter int MAXLEN  = 65535
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          spiSclk,
  input  logic          spiCsn,
  input  logic          spiMosi,
  output logic          spiMiso,
  output logic          busReq,
  output logic          busWe,
  output logic [AW-1:0] busAddr,
  output logic [7:0]    busWdata,
  input  logic [7:0]    busRdata,
  input  logic          busAck
);
  txCmd_t     txCmd;
  rxEvt_t     rxEvt;
  logic [7:0] statusQ;

  spi_bridge_shift #(.SYNC_STAGES(2)) u_shift (
    .clk(clk), .rstN(rstN), .sclk(spiSclk), .csn(spiCsn), .mosi(spiMosi),
    .txCmd(txCmd), .rxEvt(rxEvt), .miso(spiMiso)
  );

  spi_bridge_ctrl #(.AW(AW), .TIMEOUT(TIMEOUT), .MAXLEN(MAXLEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEvt(rxEvt), .txCmd(txCmd), .statusQ(statusQ),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busAck(busAck)
  );
endmodule

// File: rtl/spi_cmd_bridge_chk.sv
module spi_cmd_bridge_chk #(
  parameter int AW      = 32,
  parameter int TIMEOUT = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          spiCsn,
  input logic          busReq,
  input logic          busAck,
  input logic          busWe,
  input logic [AW-1:0] busAddr,
  input logic [7:0]    busWdata,
  input logic [7:0]    status
);
  localparam int TW = $clog2(TIMEOUT + 1);
  logic [TW-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) waitCnt <= '0;
    else if (busReq && !busAck) waitCnt <= waitCnt + 1'b1;
    else waitCnt <= '0;
  end

  // R13: request fields hold while waiting
  p_hold_stable_r13: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck && waitCnt < TW'(TIMEOUT - 1)) |=>
      (busReq && $stable(busAddr) && $stable(busWe) && $stable(busWdata)));

  // R11: last waiting cycle withdraws the request and flags timeout
  p_timeout_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck && waitCnt == TW'(TIMEOUT - 1)) |=> (!busReq && status[6]));

  // R11: no request waits longer than the limit
  p_wait_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (waitCnt < TW'(TIMEOUT)));

  // R3: bus accesses start only inside a selected frame
  p_req_in_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> !spiCsn);
endmodule

bind spi_cmd_bridge spi_cmd_bridge_chk #(.AW(AW), .TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rstN(rstN), .spiCsn(spiCsn), .busReq(busReq), .busAck(busAck),
  .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .status(statusQ)
);

// File: tb/spi_cmd_bridge_test.sv
module spi_cmd_bridge_test;
  localparam int H = 10;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0, spiCsn = 1'b1, spiMosi = 1'b0;
  logic spiMiso;
  logic busReq, busWe, busAck;
  logic [31:0] busAddr;
  logic [7:0] busWdata, busRdata;

  int nChk = 0, nBad = 0;
  logic [7:0] txBuf [16];
  logic [7:0] rxBuf [16];
  logic [7:0] mem [256];
  logic [7:0] model [256];
  logic noAck = 1'b0;
  int waitN = 0, lat = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  spi_cmd_bridge uut (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsn(spiCsn), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck)
  );

  // bus responder
  always @(posedge clk) begin
    if (!rstN) begin
      busAck <= 1'b0; busRdata <= 8'h00; waitN <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      busAck <= 1'b0;
      if (busReq && !busAck && !noAck) begin
        if (waitN >= lat) begin
          busAck <= 1'b1;
          busRdata <= mem[busAddr[7:0]];
          if (busWe) mem[busAddr[7:0]] <= busWdata;
          waitN <= 0;
          lat <= int'($urandom_range(0, 2));
        end else waitN <= waitN + 1;
      end
    end
  end

  function automatic logic [7:0] initByte(input int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n);
    spiCsn = 1'b0;
    repeat (H) @(negedge clk);
    for (int b = 0; b < n; b++)
      for (int i = 7; i >= 0; i--) begin
        spiMosi = txBuf[b][i];
        repeat (H) @(negedge clk);
        rxBuf[b][i] = spiMiso;
        spiSclk = 1'b1;
        repeat (H) @(negedge clk);
        spiSclk = 1'b0;
      end
    repeat (H) @(negedge clk);
    spiCsn = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    txBuf[0] = op; xfer(1);
  endtask

  task automatic op2(input logic [7:0] op, input logic [7:0] arg);
    txBuf[0] = op; txBuf[1] = arg; xfer(2);
  endtask

  task automatic rdStat(output logic [7:0] s);
    op2(8'h06, 8'h00); s = rxBuf[1];
  endtask

  task automatic cfg(input logic [7:0] op, input logic [31:0] a, input logic [31:0] lm1);
    txBuf[0] = op;
    for (int i = 0; i < 4; i++) begin
      txBuf[1 + i] = a[8*i +: 8];
      txBuf[5 + i] = lm1[8*i +: 8];
    end
    xfer(9);
  endtask

  task automatic clr();
    op2(8'h08, 8'hFF);
  endtask

  initial begin
    logic [7:0] s;
    logic [7:0] d [8];
    int a, n;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) model[i] = initByte(i);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    rdStat(s); check("R1 reset status", s, 8'h01);

    op1(8'h02); rdStat(s); check("R10 power off", s, 8'h00);
    op1(8'h04); rdStat(s); check("R10 power on", s, 8'h01);

    cfg(8'h0C, 32'h20, 32'd3); rdStat(s); check("R2 config write accepted", s, 8'h07);
    txBuf[0] = 8'h0E;
    for (int i = 0; i < 4; i++) begin txBuf[1+i] = 8'hA0 + 8'(i); model[32+i] = 8'hA0 + 8'(i); end
    xfer(5);
    for (int i = 0; i < 4; i++) check("R3 write byte", mem[32+i], model[32+i]);
    rdStat(s); check("R3 finish flag", s, 8'h27);

    cfg(8'h0A, 32'h1E, 32'd3);
    txBuf[0] = 8'h81; for (int i = 1; i < 5; i++) txBuf[i] = 8'h00;
    xfer(5);
    for (int i = 0; i < 4; i++) check("R4 read byte", rxBuf[1+i], model[30+i]);
    rdStat(s); check("R4 read finish", s, 8'h27);

    clr(); cfg(8'h0C, 32'h40, 32'd1);
    txBuf[0] = 8'h0E; txBuf[1] = 8'h11; txBuf[2] = 8'h22; txBuf[3] = 8'h33; txBuf[4] = 8'h44;
    xfer(5); model[64] = 8'h11; model[65] = 8'h22;
    check("R3 last in-range byte", mem[65], 8'h22);
    check("R3 excess byte ignored", mem[66], model[66]);
    rdStat(s); check("R3 finish after length", s, 8'h27);

    clr(); op2(8'h0E, 8'h99);
    rdStat(s); check("R6 write without config", s, 8'h11);
    check("R6 no bus write", mem[64], model[64]);
    clr(); cfg(8'h0C, 32'h50, 32'd0); op2(8'h81, 8'h00);
    rdStat(s); check("R6 direction mismatch", s, 8'h0F);

    clr(); op1(8'h55); rdStat(s); check("R7 unknown opcode", s, 8'h81);

    clr(); cfg(8'h0C, 32'h50, 32'd0); op1(8'h77);
    op2(8'h08, 8'h80); rdStat(s); check("R8 clear only bit7", s, 8'h07);
    op2(8'h08, 8'h01); rdStat(s); check("R8 bit0 kept", s, 8'h07);
    clr(); rdStat(s); check("R8 clear all", s, 8'h01);

    cfg(8'h0C, 32'h50, 32'h0000FFFF); rdStat(s); check("R5 over-length rejected", s, 8'h81);
    clr(); cfg(8'h0A, 32'hFFFF0050, 32'h0000FFFE); rdStat(s); check("R5 max length accepted", s, 8'h07);

    clr(); op2(8'h10, 8'h04); rdStat(s); check("R9 mode 0x04 ok", s, 8'h01);
    op2(8'h10, 8'h07); rdStat(s); check("R9 bad mode", s, 8'h81);

    clr(); noAck = 1'b1; cfg(8'h0C, 32'h60, 32'd1); op2(8'h0E, 8'h5A);
    noAck = 1'b0;
    rdStat(s); check("R11 timeout flag", s, 8'h47);
    check("R11 no write landed", mem[96], model[96]);
    op2(8'h0E, 8'h5B); rdStat(s); check("R11 config dropped", s, 8'h57);

    clr(); cfg(8'h0C, 32'h70, 32'd0);
    txBuf[0] = 8'h0C; txBuf[1] = 8'h01; txBuf[2] = 8'h02; txBuf[3] = 8'h03; xfer(4);
    rdStat(s); check("R12 partial frame discarded", s, 8'h01);
    op2(8'h0E, 8'h66); rdStat(s); check("R12 fresh opcode decode", s, 8'h11);
    check("R12 no bus write", mem[112], model[112]);

    for (int it = 0; it < 6; it++) begin
      a = int'($urandom_range(128, 240)); n = int'($urandom_range(1, 7));
      clr(); cfg(8'h0C, 32'(a), 32'(n - 1));
      txBuf[0] = 8'h0E;
      for (int i = 0; i < n; i++) begin d[i] = 8'($urandom()); txBuf[1+i] = d[i]; model[a+i] = d[i]; end
      xfer(n + 1);
      rdStat(s); check("R3 random write finish", s, 8'h27);
      clr(); cfg(8'h0A, 32'(a), 32'(n - 1));
      txBuf[0] = 8'h81; for (int i = 1; i <= n; i++) txBuf[i] = 8'h00;
      xfer(n + 1);
      for (int i = 0; i < n; i++) check("R4 random readback", rxBuf[1+i], model[a+i]);
    end

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin @(negedge clk); cyc++; end
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule